// File: doc/BRIEF.md
# Four-Way Set-Associative Read Cache

This block looks up read addresses in a small cache that stores one 32-bit word per line. The byte address splits into three fields. The two lowest bits pick a byte within the word and play no part in the lookup. The next bits pick a set, which is the word address modulo the set count. The remaining high bits form the tag. All four ways of the chosen set are compared against the tag in the same cycle. The comparator that matches, if any, drives the select of the way multiplexer directly, and a hit returns the stored word one cycle after the request is accepted.

On a miss the block raises a memory request carrying the word address and waits for a fill strobe. It then writes the tag, the word and the valid bit into a victim way and returns the filled word. An empty way is used as the victim first. Once the set is full, the least recently used way is replaced, tracked per set with age counters. Two addresses that compete for one set can therefore stay resident together. Only one lookup is outstanding at a time, and `ready_o` shows when a new one can be accepted.

Top module: `sa_cache_lookup`

## Requirements
- R1: After reset no way is valid, `ready_o` is 1, and `resp_valid_o` and `mem_req_o` are 0. The first lookup of any address misses.
- R2: The set index is address bits [IDX_W+1:2] and the tag is the bits above them. Addresses that differ only in bits [1:0] hit the same entry and return the same word. The same tag in a different set is a separate entry.
- R3: A lookup accepted (`lookup_valid_i` high while `ready_o` is 1) whose tag is resident in its set gives `resp_valid_o`=1 and `resp_hit_o`=1 in the next cycle, with the stored word on `resp_data_o`. No memory request is raised.
- R4: A lookup that misses raises `mem_req_o` in the next cycle with `mem_addr_o` equal to address bits [ADDR_W-1:2]. Both are held until `mem_fill_valid_i` is sampled high.
- R5: In the cycle after `mem_fill_valid_i` is sampled during a request, `resp_valid_o`=1, `resp_hit_o`=0, `resp_data_o` equals the fill word, and `ready_o` is 1 again. A later lookup of the same address hits with that word.
- R6: On a miss, the lowest-numbered invalid way of the set is filled, so a set holds four distinct tags before anything is evicted.
- R7: On a miss to a full set, the way least recently touched by a hit or a fill is replaced.
- R8: Two addresses that map to the same set, looked up alternately, give two misses and then only hits.
- R9: At most one way of a set matches a lookup.
- R10: `lookup_valid_i` is ignored while `ready_o` is 0. It produces no response, and it does not change the outstanding request address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lookup_valid_i | input | 1 | Lookup request strobe |
| lookup_addr_i | input | ADDR_W | Byte address to look up |
| ready_o | output | 1 | High when a lookup can be accepted |
| resp_valid_o | output | 1 | Response strobe, one cycle |
| resp_hit_o | output | 1 | 1 if the response came from a hit, 0 if it came from a fill |
| resp_data_o | output | DATA_W | Returned word |
| mem_req_o | output | 1 | Fill request outstanding |
| mem_addr_o | output | ADDR_W-2 | Word address of the fill |
| mem_fill_valid_i | input | 1 | Fill word strobe |
| mem_fill_data_i | input | DATA_W | Fill word |

## Verification
Valid, tag and data state that went wrong is seen at the next lookup of the affected set, as a wrong hit flag or a wrong word in the cycle after acceptance. Corrupted age state stays hidden until a set is full. It then appears as the wrong way being evicted, which shows as a miss where a hit is expected (or the reverse) when the evicted address is looked up again. The bench keeps its own model of tags, data and ages. It uses conflict-heavy random traffic so that evictions happen often and such differences surface within a few lookups.

// File: rtl/cache_pkg.sv
package cache_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_MISS = 1'b1
  } ctl_state_e;
endpackage

// File: rtl/cache_way_match.sv
module cache_way_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        check_i,
  input  logic [WAYS-1:0]             valid_i,
  input  logic [WAYS-1:0][TAG_W-1:0]  tags_i,
  input  logic [TAG_W-1:0]            tag_i,
  output logic [WAYS-1:0]             match_o,
  output logic                        hit_o
);
  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign match_o[g] = valid_i[g] && (tags_i[g] == tag_i);
  end
  assign hit_o = |match_o;

  // R9
  single_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    check_i |-> $onehot0(match_o));
endmodule

// File: rtl/cache_way_mux.sv
module cache_way_mux #(
  parameter int WAYS   = 4,
  parameter int DATA_W = 32
) (
  input  logic [WAYS-1:0]              sel_i,
  input  logic [WAYS-1:0][DATA_W-1:0]  data_i,
  output logic [DATA_W-1:0]            data_o
);
  // one-hot select from the comparators, AND-OR tree
  always_comb begin
    data_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      data_o = data_o | (data_i[w] & {DATA_W{sel_i[w]}});
    end
  end
endmodule

// File: rtl/cache_lru.sv
module cache_lru #(
  parameter int SETS = 8,
  parameter int WAYS = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int AGE_W = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             touch_i,
  input  logic [IDX_W-1:0] touch_set_i,
  input  logic [AGE_W-1:0] touch_way_i,
  input  logic [IDX_W-1:0] query_set_i,
  input  logic [WAYS-1:0]  valid_i,
  output logic [AGE_W-1:0] victim_o
);
  // age 0 = most recent, WAYS-1 = least recent; ages per set form a permutation
  logic [WAYS-1:0][AGE_W-1:0] age_q [SETS];
  logic [WAYS-1:0]            oldest_oh;
  logic                       found;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= AGE_W'(w);
    end else if (touch_i) begin
      for (int w = 0; w < WAYS; w++) begin
        if (AGE_W'(w) == touch_way_i)
          age_q[touch_set_i][w] <= '0;
        else if (age_q[touch_set_i][w] < age_q[touch_set_i][touch_way_i])
          age_q[touch_set_i][w] <= age_q[touch_set_i][w] + 1'b1;
      end
    end
  end

  always_comb begin
    victim_o = '0;
    found    = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      oldest_oh[w] = (age_q[query_set_i][w] == AGE_W'(WAYS - 1));
      if (!valid_i[w] && !found) begin
        victim_o = AGE_W'(w);
        found    = 1'b1;
      end
    end
    if (!found)
      for (int w = 0; w < WAYS; w++)
        if (oldest_oh[w]) victim_o = AGE_W'(w);
  end

  // R7
  lru_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(oldest_oh));
endmodule

// File: rtl/sa_cache_lookup.sv
module sa_cache_lookup
  import cache_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SETS   = 8,
  parameter int WAYS   = 4,
  parameter int DATA_W = 32,
  localparam int OFF_W = $clog2(DATA_W / 8),
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W,
  localparam int BLK_W = ADDR_W - OFF_W,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lookup_valid_i,
  input  logic [ADDR_W-1:0] lookup_addr_i,
  output logic              ready_o,
  output logic              resp_valid_o,
  output logic              resp_hit_o,
  output logic [DATA_W-1:0] resp_data_o,
  output logic              mem_req_o,
  output logic [BLK_W-1:0]  mem_addr_o,
  input  logic              mem_fill_valid_i,
  input  logic [DATA_W-1:0] mem_fill_data_i
);
  ctl_state_e                  state_q;
  logic [WAYS-1:0]             valid_q [SETS];
  logic [WAYS-1:0][TAG_W-1:0]  tag_q   [SETS];
  logic [WAYS-1:0][DATA_W-1:0] data_q  [SETS];
  logic [BLK_W-1:0]            blk_q;
  logic                        resp_valid_q, resp_hit_q;
  logic [DATA_W-1:0]           resp_data_q;

  logic [IDX_W-1:0] look_set, miss_set;
  logic [TAG_W-1:0] look_tag, miss_tag;
  logic [WAYS-1:0]  match;
  logic             hit;
  logic [DATA_W-1:0] hit_data;
  logic [WAY_W-1:0] hit_way, victim;
  logic             accept, fill;

  assign look_set = lookup_addr_i[OFF_W +: IDX_W];
  assign look_tag = lookup_addr_i[ADDR_W-1 -: TAG_W];
  assign miss_set = blk_q[IDX_W-1:0];
  assign miss_tag = blk_q[BLK_W-1 -: TAG_W];
  assign accept   = (state_q == ST_IDLE) && lookup_valid_i;
  assign fill     = (state_q == ST_MISS) && mem_fill_valid_i;

  cache_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .check_i (accept),
    .valid_i (valid_q[look_set]),
    .tags_i  (tag_q[look_set]),
    .tag_i   (look_tag),
    .match_o (match),
    .hit_o   (hit)
  );

  cache_way_mux #(.WAYS(WAYS), .DATA_W(DATA_W)) u_mux (
    .sel_i  (match),
    .data_i (data_q[look_set]),
    .data_o (hit_data)
  );

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (match[w]) hit_way = WAY_W'(w);
  end

  cache_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .touch_i     ((accept && hit) || fill),
    .touch_set_i (fill ? miss_set : look_set),
    .touch_way_i (fill ? victim : hit_way),
    .query_set_i (miss_set),
    .valid_i     (valid_q[miss_set]),
    .victim_o    (victim)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      blk_q        <= '0;
      resp_valid_q <= 1'b0;
      resp_hit_q   <= 1'b0;
      resp_data_q  <= '0;
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        tag_q[s]   <= '0;
        data_q[s]  <= '0;
      end
    end else begin
      resp_valid_q <= 1'b0;
      if (accept) begin
        if (hit) begin
          resp_valid_q <= 1'b1;
          resp_hit_q   <= 1'b1;
          resp_data_q  <= hit_data;
        end else begin
          state_q <= ST_MISS;
          blk_q   <= lookup_addr_i[ADDR_W-1:OFF_W];
        end
      end else if (fill) begin
        valid_q[miss_set][victim] <= 1'b1;
        tag_q[miss_set][victim]   <= miss_tag;
        data_q[miss_set][victim]  <= mem_fill_data_i;
        resp_valid_q <= 1'b1;
        resp_hit_q   <= 1'b0;
        resp_data_q  <= mem_fill_data_i;
        state_q      <= ST_IDLE;
      end
    end
  end

  assign ready_o      = (state_q == ST_IDLE);
  assign resp_valid_o = resp_valid_q;
  assign resp_hit_o   = resp_hit_q;
  assign resp_data_o  = resp_data_q;
  assign mem_req_o    = (state_q == ST_MISS);
  assign mem_addr_o   = blk_q;

  // R4
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_fill_valid_i) |=> (mem_req_o && $stable(mem_addr_o)));
  // R5
  fill_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_fill_valid_i) |=>
      (resp_valid_o && !resp_hit_o && resp_data_o == $past(mem_fill_data_i) && ready_o));
  // R10
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && lookup_valid_i && !mem_fill_valid_i) |=> !resp_valid_o);
  // R3
  hit_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && resp_hit_o) |-> (!mem_req_o && $past(ready_o && lookup_valid_i)));
endmodule

// File: tb/sa_cache_lookup_test.sv
`timescale 1ns/1ps
module sa_cache_lookup_test;
  localparam int ADDR_W = 16, SETS = 8, WAYS = 4;

  logic        clk = 0, rst_n = 0;
  logic        lookup_valid = 0;
  logic [15:0] lookup_addr = '0;
  logic        ready, resp_valid, resp_hit, mem_req, fill_valid = 0;
  logic [31:0] resp_data, fill_data = '0;
  logic [13:0] mem_addr;

  int n_chk = 0, n_bad = 0;

  sa_cache_lookup #(.ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS)) uut (
    .clk_i(clk), .rst_ni(rst_n), .lookup_valid_i(lookup_valid), .lookup_addr_i(lookup_addr),
    .ready_o(ready), .resp_valid_o(resp_valid), .resp_hit_o(resp_hit), .resp_data_o(resp_data),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_fill_valid_i(fill_valid),
    .mem_fill_data_i(fill_data));

  always #5 clk = ~clk;

  // reference model
  bit          m_valid [SETS][WAYS];
  logic [10:0] m_tag   [SETS][WAYS];
  logic [31:0] m_data  [SETS][WAYS];
  int          m_age   [SETS][WAYS];
  int          m_hits = 0, m_miss = 0, d_hits = 0, d_miss = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_predict(input logic [15:0] a, output bit h, output logic [31:0] d, output int way);
    int s = int'(a[4:2]);
    h = 0; d = '0; way = -1;
    for (int w = 0; w < WAYS; w++)
      if (m_valid[s][w] && m_tag[s][w] == a[15:5]) begin h = 1; d = m_data[s][w]; way = w; end
    if (!h) begin
      for (int w = WAYS - 1; w >= 0; w--) if (!m_valid[s][w]) way = w;
      if (way < 0) for (int w = 0; w < WAYS; w++) if (m_age[s][w] == WAYS - 1) way = w;
    end
  endtask

  task automatic model_commit(input logic [15:0] a, input int way, input logic [31:0] d);
    int s = int'(a[4:2]);
    int old = m_age[s][way];
    m_valid[s][way] = 1; m_tag[s][way] = a[15:5]; m_data[s][way] = d;
    for (int w = 0; w < WAYS; w++)
      if (w == way) m_age[s][w] = 0;
      else if (m_age[s][w] < old) m_age[s][w]++;
  endtask

  // want: -1 = no directed expectation, 0 = miss, 1 = hit
  task automatic access(input logic [15:0] a, input int want, input int waits, input bit poke, input string req);
    bit eh; logic [31:0] ed; int ew; logic [31:0] fd;
    model_predict(a, eh, ed, ew);
    if (want >= 0) check(eh == bit'(want), {req, " directed hit expectation"}, 32'(eh), 32'(want));
    @(negedge clk);
    check(ready, "R1 ready before lookup", 32'(ready), 1);
    lookup_valid = 1; lookup_addr = a;
    @(negedge clk);
    lookup_valid = 0;
    if (eh) begin
      m_hits++;
      if (resp_valid && resp_hit) d_hits++;
      check(resp_valid && resp_hit && !mem_req, {req, " R3 hit response"}, {resp_valid, resp_hit, mem_req}, 3'b110);
      check(resp_data == ed, {req, " R3 hit data"}, resp_data, ed);
    end else begin
      m_miss++;
      if (mem_req) d_miss++;
      check(mem_req && !resp_valid, {req, " R4 miss request"}, {mem_req, resp_valid}, 2'b10);
      check(mem_addr == a[15:2], {req, " R4 request address"}, 32'(mem_addr), 32'(a[15:2]));
      for (int i = 0; i < waits; i++) begin
        if (poke) begin lookup_valid = 1; lookup_addr = a ^ 16'h0104; end
        @(negedge clk);
        lookup_valid = 0;
        check(mem_req && !resp_valid && mem_addr == a[15:2], "R10 busy lookup ignored",
              {mem_req, resp_valid, 16'(mem_addr)}, {2'b10, 16'(a[15:2])});
      end
      fd = $urandom;
      fill_valid = 1; fill_data = fd;
      @(negedge clk);
      fill_valid = 0;
      check(resp_valid && !resp_hit && ready, {req, " R5 fill response"}, {resp_valid, resp_hit, ready}, 3'b101);
      check(resp_data == fd, {req, " R5 fill data"}, resp_data, fd);
      ed = fd;
    end
    model_commit(a, ew, ed);
  endtask

  function automatic logic [15:0] mk(input int tag, input int set, input int off);
    return {11'(tag), 3'(set), 2'(off)};
  endfunction

  initial begin
    void'($urandom(32'd2652));
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin m_valid[s][w] = 0; m_age[s][w] = w; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(ready && !resp_valid && !mem_req, "R1 reset outputs", {ready, resp_valid, mem_req}, 3'b100);

    access(mk(3, 5, 0), 0, 0, 0, "R1 first access");
    // R8 ping-pong pair
    access(mk(9, 5, 0), 0, 2, 0, "R8");
    for (int i = 0; i < 4; i++) access(mk((i % 2) ? 9 : 3, 5, 0), 1, 0, 0, "R8");
    // R2 offset and set split
    access(mk(3, 5, 3), 1, 0, 0, "R2 offset");
    access(mk(3, 6, 1), 0, 1, 0, "R2 other set");
    // R10 pokes while busy
    access(mk(20, 1, 0), 0, 3, 1, "R10");
    access(mk(20, 1, 2), 1, 0, 0, "R10 resident");
    // R6 fill four ways, R7 LRU eviction
    for (int t = 0; t < 4; t++) access(mk(t, 2, 0), 0, 0, 0, "R6");
    for (int t = 0; t < 4; t++) access(mk(t, 2, 0), 1, 0, 0, "R6 all resident");
    access(mk(0, 2, 0), 1, 0, 0, "R7");
    access(mk(4, 2, 0), 0, 0, 0, "R7");   // evicts tag 1
    access(mk(0, 2, 0), 1, 0, 0, "R7");
    access(mk(1, 2, 0), 0, 0, 0, "R7");   // evicts tag 2
    access(mk(3, 2, 0), 1, 0, 0, "R7");
    access(mk(4, 2, 0), 1, 0, 0, "R7");
    access(mk(2, 2, 0), 0, 0, 0, "R7");

    // constrained random, conflict heavy
    for (int i = 0; i < 400; i++)
      access(mk($urandom_range(0, 5), $urandom_range(0, 3), $urandom_range(0, 3)), -1,
             $urandom_range(0, 3), 1'($urandom_range(0, 1)), "R9 random");
    check(d_hits == m_hits && d_miss == m_miss, "R9 hit/miss totals", 32'(d_hits), 32'(m_hits));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule